// File: doc/BRIEF.md
# Clock Source Control Register with Interlocks

This block is the control register of a small clock-management unit. Software sets and clears enables for an external high-speed oscillator, a main PLL and a secondary PLL. It also sets an oscillator bypass bit and a clock-monitor enable. Reading the register shows these bits together with read-only ready flags and an 8-bit calibration value. The analog oscillator and the PLLs sit outside the block and are seen only through lock and stability inputs. The system-clock switch also sits outside and reports which source drives the system clock now and which one it has been asked to switch to.

Every software write passes through a protection filter. A write cannot switch off a source that feeds the system clock, or that is about to feed it. A write of 1 to any enable always takes effect. Entering a low-power mode clears the three source enables in hardware, and this overrides both the filter and any write made in the same cycle. The oscillator ready flag does not drop the moment the oscillator is disabled. It is produced in the oscillator's own clock domain and falls only after a fixed number of oscillator cycles. It is then synchronized into the register clock domain.

Top module: `clk_src_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all five control bits (main-PLL enable, secondary-PLL enable, oscillator enable, bypass, monitor enable) and the read data. It also loads the calibration field from `cal_init`.
- R2: Writing 1 to bit 24 sets the main-PLL enable. Writing 0 clears it, unless `sys_sel` or `sys_req` equals 2 (main PLL); in that case the write leaves the bit at 1.
- R3: Writing 1 to bit 26 sets the secondary-PLL enable. Writing 0 clears it, unless `sys_sel` equals 2 and `pll_in_sel` equals 2 (secondary PLL feeds the main PLL).
- R4: Writing 1 to bit 16 sets the oscillator enable. Writing 0 clears it, unless one of these holds: `sys_sel` or `sys_req` equals 1 (oscillator direct); or `sys_sel` or `sys_req` equals 2 while `pll_in_sel` is 1 (oscillator) or 2 (secondary PLL).
- R5: Bit 18 (bypass) takes the written value only when the oscillator enable was 0 before the write. Otherwise the bypass bit keeps its value.
- R6: `lp_enter` high clears the main-PLL, secondary-PLL and oscillator enables at the next edge. This overrides the interlocks and any write in the same cycle. Bypass and monitor enable still follow the write rules.
- R7: Read bits 25 and 27 show `pll_lock` and `pll2_lock` (1 = locked) through a two-stage synchronizer.
- R8: While the enable (seen through a two-stage synchronizer on `osc_clk`) is 1, the oscillator-domain ready follows `osc_stable`. Once the synchronized enable is seen at 0, that ready falls on the sixth `osc_clk` edge. It is then synchronized over two `clk` stages and read as bit 17.
- R9: `monitor_on` is the monitor enable (bit 19) AND the synchronized oscillator ready.
- R10: `rd_data` is updated one cycle after `rd_en` with the register image, and is 0 after a cycle without `rd_en`. Bits 31:28, 23:20 and 7:0 always read 0.
- R11: The calibration field (bits 15:8) is not changed by any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_clk | input | 1 | Oscillator clock for the ready-fall counter |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | One-cycle read strobe |
| rd_data | output | 32 | Registered read data |
| lp_enter | input | 1 | Low-power mode entry |
| sys_sel | input | 2 | Current system-clock source: 0 internal RC, 1 oscillator, 2 main PLL |
| sys_req | input | 2 | Requested system-clock source, same encoding |
| pll_in_sel | input | 2 | Main-PLL input: 0 internal RC, 1 oscillator, 2 secondary PLL |
| pll_lock | input | 1 | Main PLL locked |
| pll2_lock | input | 1 | Secondary PLL locked |
| osc_stable | input | 1 | Oscillator stable, in the `osc_clk` domain |
| cal_init | input | 8 | Calibration value loaded at reset |
| pll_en | output | 1 | Main-PLL enable |
| pll2_en | output | 1 | Secondary-PLL enable |
| osc_en | output | 1 | Oscillator enable |
| osc_bypass | output | 1 | Oscillator bypass |
| monitor_on | output | 1 | Effective clock-monitor enable |

## Verification
A wrong control bit caused by the write filter shows on `pll_en`, `pll2_en`, `osc_en` or `osc_bypass` at the first edge after the offending write or low-power entry. The bench compares these outputs against a behavioural model on every cycle, so the error is caught at once. A wrong ready flag or counter in the oscillator domain shows in bit 17 of the read data and on `monitor_on`. Its delay is the two oscillator synchronizer stages, plus the six-edge fall window, plus two register-clock stages. Reads are issued often, so the error appears within about twenty register cycles. Lock flags appear in the read data two cycles after the lock inputs change.

// File: rtl/csc_pkg.sv
package csc_pkg;

    localparam int REG_W = 32;
    localparam int CAL_W = 8;
    localparam int CAL_LSB = 8;

    // field positions in the register image
    localparam int POS_PLL2_RDY = 27;
    localparam int POS_PLL2_ON  = 26;
    localparam int POS_PLL_RDY  = 25;
    localparam int POS_PLL_ON   = 24;
    localparam int POS_MON      = 19;
    localparam int POS_BYP      = 18;
    localparam int POS_OSC_RDY  = 17;
    localparam int POS_OSC_ON   = 16;

    typedef enum logic [1:0] {
        SYS_RC  = 2'd0,
        SYS_OSC = 2'd1,
        SYS_PLL = 2'd2,
        SYS_RSV = 2'd3
    } sys_src_e;

    typedef enum logic [1:0] {
        PIN_RC   = 2'd0,
        PIN_OSC  = 2'd1,
        PIN_PLL2 = 2'd2,
        PIN_RSV  = 2'd3
    } pll_in_e;

    typedef struct packed {
        logic pll2_on;
        logic pll_on;
        logic mon_en;
        logic byp;
        logic osc_on;
    } ctrl_t;

    typedef struct packed {
        logic pll2_rdy;
        logic pll_rdy;
        logic osc_rdy;
    } stat_t;

    typedef struct packed {
        logic pll;
        logic pll2;
        logic osc;
    } hold_t;

    // which enables must not be cleared by software in the present clock tree
    function automatic hold_t calc_hold(sys_src_e cur, sys_src_e nxt, pll_in_e pin);
        hold_t h;
        logic  pll_used;
        logic  pll_from_osc;
        pll_used     = (cur == SYS_PLL) || (nxt == SYS_PLL);
        pll_from_osc = (pin == PIN_OSC) || (pin == PIN_PLL2);
        h.pll  = pll_used;
        h.pll2 = (cur == SYS_PLL) && (pin == PIN_PLL2);
        h.osc  = (cur == SYS_OSC) || (nxt == SYS_OSC) || (pll_used && pll_from_osc);
        return h;
    endfunction

    // filtered software write: sets always pass, clears pass unless held
    function automatic ctrl_t apply_write(ctrl_t cur, logic [REG_W-1:0] wd, hold_t h);
        ctrl_t n;
        n.pll_on  = wd[POS_PLL_ON]  | (cur.pll_on  & h.pll);
        n.pll2_on = wd[POS_PLL2_ON] | (cur.pll2_on & h.pll2);
        n.osc_on  = wd[POS_OSC_ON]  | (cur.osc_on  & h.osc);
        n.mon_en  = wd[POS_MON];
        n.byp     = cur.osc_on ? cur.byp : wd[POS_BYP];
        return n;
    endfunction

    function automatic logic [REG_W-1:0] pack_image(ctrl_t c, stat_t s, logic [CAL_W-1:0] cal);
        logic [REG_W-1:0] img;
        img = '0;
        img[POS_PLL2_RDY] = s.pll2_rdy;
        img[POS_PLL2_ON]  = c.pll2_on;
        img[POS_PLL_RDY]  = s.pll_rdy;
        img[POS_PLL_ON]   = c.pll_on;
        img[POS_MON]      = c.mon_en;
        img[POS_BYP]      = c.byp;
        img[POS_OSC_RDY]  = s.osc_rdy;
        img[POS_OSC_ON]   = c.osc_on;
        img[CAL_LSB +: CAL_W] = cal;
        return img;
    endfunction

endpackage

// File: rtl/csc_sync.sv
module csc_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int CHAIN_W = WIDTH * STAGES;

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

    initial begin
        if (STAGES < 2 || CHAIN_W < 2) $error("csc_sync needs at least two stages");
    end
endmodule

// File: rtl/csc_guard.sv
module csc_guard
    import csc_pkg::*;
(
    input  sys_src_e cur_src,
    input  sys_src_e next_src,
    input  pll_in_e  pll_in,
    output hold_t    hold
);
    always_comb begin
        hold = calc_hold(cur_src, next_src, pll_in);
    end
endmodule

// File: rtl/csc_osc_ready.sv
module csc_osc_ready #(
    parameter int FALL_CYCLES = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic osc_clk,
    input  logic rst,
    input  logic en_req,
    input  logic osc_stable,
    output logic rdy_osc
);
    localparam int CNT_W = $clog2(FALL_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FALL_CYCLES - 1);

    logic             en_sync;
    logic [CNT_W-1:0] cnt;
    logic             rdy_q;

    csc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_en_sync (
        .clk (osc_clk),
        .rst (rst),
        .d   (en_req),
        .q   (en_sync)
    );

    always_ff @(posedge osc_clk) begin
        if (rst) begin
            cnt   <= '0;
            rdy_q <= 1'b0;
        end else if (en_sync) begin
            cnt   <= '0;
            rdy_q <= osc_stable;
        end else if (rdy_q) begin
            if (cnt == LAST) begin
                cnt   <= '0;
                rdy_q <= 1'b0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end else begin
            cnt <= '0;
        end
    end

    assign rdy_osc = rdy_q;

    // R8: with the oscillator disabled the ready flag can never rise
    p_no_rise_when_off_r8: assert property (@(posedge osc_clk) disable iff (rst)
        !en_sync |=> !$rose(rdy_q));

    // R8: the fall window never expires before the counter has run
    p_hold_during_window_r8: assert property (@(posedge osc_clk) disable iff (rst)
        (!en_sync && rdy_q && cnt == '0) |=> rdy_q);
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
    import csc_pkg::*;
#(
    parameter int FALL_CYCLES = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        osc_clk,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    output logic [31:0] rd_data,
    input  logic        lp_enter,
    input  logic [1:0]  sys_sel,
    input  logic [1:0]  sys_req,
    input  logic [1:0]  pll_in_sel,
    input  logic        pll_lock,
    input  logic        pll2_lock,
    input  logic        osc_stable,
    input  logic [7:0]  cal_init,
    output logic        pll_en,
    output logic        pll2_en,
    output logic        osc_en,
    output logic        osc_bypass,
    output logic        monitor_on
);
    localparam logic [REG_W-1:0] RSV_MASK = 32'hF0F0_00FF;

    ctrl_t            ctrl_q;
    ctrl_t            ctrl_d;
    hold_t            hold;
    stat_t            stat;
    logic [CAL_W-1:0] cal_q;
    logic [REG_W-1:0] rd_q;
    logic [1:0]       lock_sync;
    logic             rdy_osc;
    logic             rdy_sync;

    csc_guard u_guard (
        .cur_src  (sys_src_e'(sys_sel)),
        .next_src (sys_src_e'(sys_req)),
        .pll_in   (pll_in_e'(pll_in_sel)),
        .hold     (hold)
    );

    csc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_lock_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pll2_lock, pll_lock}),
        .q   (lock_sync)
    );

    csc_osc_ready #(.FALL_CYCLES(FALL_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_osc_rdy (
        .osc_clk    (osc_clk),
        .rst        (rst),
        .en_req     (ctrl_q.osc_on),
        .osc_stable (osc_stable),
        .rdy_osc    (rdy_osc)
    );

    csc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_rdy_sync (
        .clk (clk),
        .rst (rst),
        .d   (rdy_osc),
        .q   (rdy_sync)
    );

    always_comb begin
        stat.pll2_rdy = lock_sync[1];
        stat.pll_rdy  = lock_sync[0];
        stat.osc_rdy  = rdy_sync;
    end

    // write filter, then low-power entry overrides the source enables
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d = apply_write(ctrl_q, wr_data, hold);
        end
        if (lp_enter) begin
            ctrl_d.pll_on  = 1'b0;
            ctrl_d.pll2_on = 1'b0;
            ctrl_d.osc_on  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cal_q  <= cal_init;
            rd_q   <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            rd_q   <= rd_en ? pack_image(ctrl_q, stat, cal_q) : '0;
        end
    end

    assign rd_data    = rd_q;
    assign pll_en     = ctrl_q.pll_on;
    assign pll2_en    = ctrl_q.pll2_on;
    assign osc_en     = ctrl_q.osc_on;
    assign osc_bypass = ctrl_q.byp;
    assign monitor_on = ctrl_q.mon_en & stat.osc_rdy;

    // R2: main PLL stays on while it drives or is about to drive the system clock
    p_pll_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.pll_on && (sys_sel == 2'd2 || sys_req == 2'd2) && !lp_enter) |=> ctrl_q.pll_on);

    // R3: secondary PLL stays on while it feeds the main PLL that drives the system clock
    p_pll2_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.pll2_on && sys_sel == 2'd2 && pll_in_sel == 2'd2 && !lp_enter) |=> ctrl_q.pll2_on);

    // R4: oscillator stays on while it drives the system clock directly
    p_osc_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.osc_on && (sys_sel == 2'd1 || sys_req == 2'd1) && !lp_enter) |=> ctrl_q.osc_on);

    // R5: bypass is frozen while the oscillator is enabled
    p_bypass_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.osc_on |=> $stable(ctrl_q.byp));

    // R6: low-power entry leaves every source enable cleared
    p_lp_clear_r6: assert property (@(posedge clk) disable iff (rst)
        lp_enter |=> !(ctrl_q.pll_on || ctrl_q.pll2_on || ctrl_q.osc_on));

    // R10: an idle cycle returns zero; reserved bits never set
    p_idle_read_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rd_q == '0));
    p_rsv_zero_r10: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> ((rd_q & RSV_MASK) == '0));

    // R11: writes never reach the calibration field
    p_cal_fixed_r11: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> $stable(cal_q));
endmodule

// File: tb/clk_src_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_src_ctrl_tb_top;

    localparam int WATCHDOG = 50000;
    localparam logic [7:0] CAL = 8'h5A;

    logic        clk = 1'b0;
    logic        osc_clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        lp_enter = 1'b0;
    logic [1:0]  sys_sel = 2'd0;
    logic [1:0]  sys_req = 2'd0;
    logic [1:0]  pll_in_sel = 2'd0;
    logic        pll_lock = 1'b0;
    logic        pll2_lock = 1'b0;
    logic        osc_stable = 1'b1;
    logic        pll_en, pll2_en, osc_en, osc_bypass, monitor_on;

    int checks = 0;
    int failures = 0;
    bit cmp_on = 0;

    always #4 clk = ~clk;
    always #10 osc_clk = ~osc_clk;

    clk_src_ctrl dut_i (
        .clk(clk), .rst(rst), .osc_clk(osc_clk),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .lp_enter(lp_enter), .sys_sel(sys_sel), .sys_req(sys_req), .pll_in_sel(pll_in_sel),
        .pll_lock(pll_lock), .pll2_lock(pll2_lock), .osc_stable(osc_stable), .cal_init(CAL),
        .pll_en(pll_en), .pll2_en(pll2_en), .osc_en(osc_en), .osc_bypass(osc_bypass),
        .monitor_on(monitor_on)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit       m_pll, m_pll2, m_osc, m_mon, m_byp;
    bit [7:0] m_cal;
    bit [31:0] m_rd;
    bit [1:0] m_lk;
    bit       m_ordy;
    bit [1:0] lkq[$];
    bit       rq[$];
    bit       oq[$];
    bit       o_rdy;
    int       o_cnt;
    bit       n_pll, n_pll2, n_osc, n_mon, n_byp, busy, en_seen;
    bit [31:0] img;

    always @(posedge clk) begin
        if (rst) begin
            m_pll <= 0; m_pll2 <= 0; m_osc <= 0; m_mon <= 0; m_byp <= 0;
            m_cal <= CAL; m_rd <= 0; m_lk <= 0; m_ordy <= 0;
            lkq.delete(); lkq.push_back(2'b00);
            rq.delete();  rq.push_back(1'b0);
        end else begin
            busy = (sys_sel == 2'd2) || (sys_req == 2'd2);
            n_pll = m_pll; n_pll2 = m_pll2; n_osc = m_osc; n_mon = m_mon; n_byp = m_byp;
            if (wr_en) begin
                if (wr_data[24]) n_pll = 1;
                else if (!busy) n_pll = 0;
                if (wr_data[26]) n_pll2 = 1;
                else if (!(sys_sel == 2'd2 && pll_in_sel == 2'd2)) n_pll2 = 0;
                if (wr_data[16]) n_osc = 1;
                else if (!(sys_sel == 2'd1 || sys_req == 2'd1 ||
                           (busy && (pll_in_sel == 2'd1 || pll_in_sel == 2'd2)))) n_osc = 0;
                n_mon = wr_data[19];
                if (!m_osc) n_byp = wr_data[18];
            end
            if (lp_enter) begin
                n_pll = 0; n_pll2 = 0; n_osc = 0;
            end
            img = 32'h0;
            img[27] = m_lk[1]; img[26] = m_pll2; img[25] = m_lk[0]; img[24] = m_pll;
            img[19] = m_mon;   img[18] = m_byp;  img[17] = m_ordy;  img[16] = m_osc;
            img[15:8] = m_cal;
            m_rd <= rd_en ? img : 32'h0;
            m_pll <= n_pll; m_pll2 <= n_pll2; m_osc <= n_osc; m_mon <= n_mon; m_byp <= n_byp;
            m_lk <= lkq.pop_front();
            lkq.push_back({pll2_lock, pll_lock});
            m_ordy <= rq.pop_front();
            rq.push_back(o_rdy);
        end
    end

    always @(posedge osc_clk) begin
        if (rst) begin
            oq.delete(); oq.push_back(1'b0); oq.push_back(1'b0);
            o_rdy = 0; o_cnt = 0;
        end else begin
            en_seen = oq.pop_front();
            oq.push_back(m_osc);
            if (en_seen) begin
                o_rdy = osc_stable; o_cnt = 0;
            end else if (o_rdy) begin
                o_cnt++;
                if (o_cnt == 6) begin o_rdy = 0; o_cnt = 0; end
            end else begin
                o_cnt = 0;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            chk("R2 pll_en", {31'b0, pll_en}, {31'b0, m_pll});
            chk("R3 pll2_en", {31'b0, pll2_en}, {31'b0, m_pll2});
            chk("R4 osc_en", {31'b0, osc_en}, {31'b0, m_osc});
            chk("R5 osc_bypass", {31'b0, osc_bypass}, {31'b0, m_byp});
            chk("R9 monitor_on", {31'b0, monitor_on}, {31'b0, m_mon & m_ordy});
            chk("R10 rd_data", rd_data, m_rd);
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_wr(input logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd_chk(input string req, input logic [31:0] mask, input logic [31:0] exp);
        @(negedge clk); rd_en = 1;
        @(negedge clk); rd_en = 0;
        chk(req, rd_data & mask, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        idle(10);
        rst = 0;
        idle(1);
        cmp_on = 1;

        // R1: reset state
        chk("R1 enables", {27'b0, pll_en, pll2_en, osc_en, osc_bypass, monitor_on}, 32'h0);
        rd_chk("R1 image", 32'hFFFF_FFFF, 32'h0000_5A00);

        // R5/R8: enable oscillator with bypass while it is off
        do_wr(32'h0005_0000);
        chk("R5 bypass written", {31'b0, osc_bypass}, 32'h1);
        idle(30);
        rd_chk("R8 ready risen", 32'hFFFF_FFFF, 32'h0007_5A00);

        // R5: bypass clear ignored while oscillator is on
        do_wr(32'h0001_0000);
        chk("R5 bypass frozen", {31'b0, osc_bypass}, 32'h1);

        // R9: monitor on once enabled and oscillator ready
        do_wr(32'h0009_0000);
        chk("R9 monitor on", {31'b0, monitor_on}, 32'h1);

        // R7: lock flags
        pll_lock = 1; pll2_lock = 1;
        idle(3);
        rd_chk("R7 lock flags", 32'h0A00_0000, 32'h0A00_0000);

        // enable both PLLs
        do_wr(32'h0509_0000);
        sys_sel = 2'd2; pll_in_sel = 2'd2;
        do_wr(32'h0000_0000);
        chk("R2 pll held", {31'b0, pll_en}, 32'h1);
        chk("R3 pll2 held", {31'b0, pll2_en}, 32'h1);
        chk("R4 osc held via pll2", {31'b0, osc_en}, 32'h1);
        chk("R9 monitor off", {31'b0, monitor_on}, 32'h0);

        pll_in_sel = 2'd1;
        do_wr(32'h0000_0000);
        chk("R3 pll2 released", {31'b0, pll2_en}, 32'h0);
        chk("R4 osc held via pll", {31'b0, osc_en}, 32'h1);

        // R2 by request; R4 released; R8 delayed fall
        sys_sel = 2'd0; sys_req = 2'd2; pll_in_sel = 2'd0;
        do_wr(32'h0400_0000);
        chk("R2 pll held by request", {31'b0, pll_en}, 32'h1);
        chk("R4 osc released", {31'b0, osc_en}, 32'h0);
        rd_chk("R8 ready still high", 32'h0002_0000, 32'h0002_0000);
        idle(30);
        rd_chk("R8 ready fallen", 32'h0002_0000, 32'h0);

        // oscillator direct, request cleared
        do_wr(32'h0501_0000);
        sys_sel = 2'd1; sys_req = 2'd0;
        do_wr(32'h0000_0000);
        chk("R2 pll released", {31'b0, pll_en}, 32'h0);
        chk("R4 osc held direct", {31'b0, osc_en}, 32'h1);

        // R6: low-power entry with a simultaneous write of ones
        do_wr(32'h0501_0000);
        @(negedge clk); lp_enter = 1; wr_en = 1; wr_data = 32'hFFFF_FFFF;
        @(negedge clk); lp_enter = 0; wr_en = 0;
        chk("R6 enables cleared", {29'b0, pll_en, pll2_en, osc_en}, 32'h0);
        rd_chk("R6 mon kept by write", 32'h0509_0000, 32'h0008_0000);
        rd_chk("R11 cal unchanged", 32'h0000_FF00, 32'h0000_5A00);
        rd_chk("R10 reserved zero", 32'hF0F0_00FF, 32'h0);

        // random phase, checked by the model every cycle
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            wr_en    = ($urandom_range(3) == 0);
            wr_data  = $urandom;
            rd_en    = $urandom_range(1);
            lp_enter = ($urandom_range(39) == 0);
            if ($urandom_range(7) == 0) sys_sel = 2'($urandom_range(3));
            if ($urandom_range(7) == 0) sys_req = 2'($urandom_range(3));
            if ($urandom_range(7) == 0) pll_in_sel = 2'($urandom_range(3));
            if ($urandom_range(15) == 0) pll_lock = ~pll_lock;
            if ($urandom_range(15) == 0) pll2_lock = ~pll2_lock;
            if ($urandom_range(31) == 0) osc_stable = ~osc_stable;
        end
        @(negedge clk);
        wr_en = 0; rd_en = 0; lp_enter = 0;
        idle(2);
        finish_run();
    end
endmodule